// File: doc/BRIEF.md
# Dual-Buffer Byte-Wide Command Front End

This block sits on the device side of a page-organized flash memory whose host link is one byte wide and synchronous. While chip select is held low the host streams bytes in: one command byte, three address bytes, any dummy bytes the command needs, then write data. Read data streams back out. Two 264-byte SRAM buffers live inside the block. Page reads come from an external array model over a simple combinational read port. A program-through-buffer command ends with a one-cycle start pulse to the array sequencer when chip select rises.

Both byte streams use valid/ready. The inbound stream (`in_valid`/`in_ready`) is taken only while `cs_n` is low. `in_ready` drops only while a read command is in its data phase, because no inbound bytes are meaningful then. The outbound stream (`out_valid`/`out_ready`) offers a byte only in the data phase of a read. When the host holds `out_ready` low, `out_data` stays unchanged and the read position does not move. `cs_n`, the array port and the start pulse are plain signals.

Top module: `dbuf_cmd_front`

## Requirements
- R1: During and right after reset, `out_en`, `out_valid` and `prog_start` are 0 and `in_ready` is 1.
- R2: Command 84h (buffer 0) or 87h (buffer 1) writes each data byte after the three address bytes into the chosen buffer. The first byte goes to the 9-bit byte address held in the low nine bits of the 24-bit address. The index then steps by one and returns from 263 to 0.
- R3: Command 54h (buffer 0) or 56h (buffer 1) offers no output until three address bytes and one dummy byte have been accepted. It then streams the chosen buffer from the low-nine-bit byte address, and the index returns from 263 to 0.
- R4: A 9-bit byte address of 264 or more is reduced by 264 before use, so address 300 selects byte 36.
- R5: Command 52h offers no output until three address bytes and 60 dummy bytes have been accepted. It then streams array data for page address bits [20:9] and byte address bits [8:0]. The byte index returns from 263 to 0 on the same page. Bits [23:21] are ignored.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `in_ready` is 0.
- R7: While `cs_n` is 1, `out_en` and `out_valid` are 0.
- R8: Command 82h (buffer 0) or 85h (buffer 1) loads data into the buffer as R2 does. When `cs_n` rises, `prog_start` is 1 for exactly one cycle, with `page_addr` equal to address bits [20:9] and `prog_buf` naming the buffer.
- R9: An unknown command byte is ignored until `cs_n` rises. The bytes that follow are accepted and discarded, no output is driven, no buffer changes and no start pulse occurs.
- R10: A program command whose transaction ends before all three address bytes arrive raises no `prog_start`. Neither does any non-program command.
- R11: Writes to one buffer leave the other buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low for the length of a transaction |
| in_valid | input | 1 | Inbound byte present |
| in_ready | output | 1 | Inbound byte taken on this edge when valid |
| in_data | input | 8 | Command, address, dummy or write byte |
| out_valid | output | 1 | Read byte offered |
| out_ready | input | 1 | Host takes the offered byte |
| out_data | output | 8 | Read byte |
| out_en | output | 1 | Output drive enable; 0 means high impedance |
| page_addr | output | 12 | Captured page address, for array reads and programming |
| byte_addr | output | 9 | Current byte index within page or buffer |
| arr_rd_data | input | 8 | Array byte at `page_addr`/`byte_addr` |
| prog_start | output | 1 | One-cycle erase-and-program request |
| prog_buf | output | 1 | Buffer used by the program request |

## Verification
The hardest state to reach is the byte after the last index of a page read. Getting there takes a full 24-bit address with the page field in the middle, then sixty dummy bytes, and only after that can the wrap from 263 to 0 be seen at the output. The bench places the start address at 262 and counts out 59 dummy bytes to confirm the output is still silent. It then sends the sixtieth byte and pulls three bytes across the wrap against an array model computed in the bench. The same near-end starting point is used for the buffer paths. The hold-off test parks `out_ready` low in the middle of a buffer read.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam logic [7:0] OPC_PG_RD   = 8'h52;
  localparam logic [7:0] OPC_B0_RD   = 8'h54;
  localparam logic [7:0] OPC_B1_RD   = 8'h56;
  localparam logic [7:0] OPC_B0_WR   = 8'h84;
  localparam logic [7:0] OPC_B1_WR   = 8'h87;
  localparam logic [7:0] OPC_B0_PROG = 8'h82;
  localparam logic [7:0] OPC_B1_PROG = 8'h85;

  typedef enum logic [2:0] {
    K_NONE, K_PGRD, K_BUFRD, K_BUFWR, K_PGPROG
  } kind_t;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP
  } phase_t;
endpackage

// File: rtl/dbuf_opdec.sv
module dbuf_opdec
  import dbuf_pkg::*;
#(
  parameter int PG_DUMMY  = 60,
  parameter int BUF_DUMMY = 1,
  parameter int DCNT_W    = 6
) (
  input  logic [7:0]        opc,
  output kind_t             kind,
  output logic              bsel,
  output logic [DCNT_W-1:0] dummies
);
  always_comb begin
    kind    = K_NONE;
    bsel    = 1'b0;
    dummies = '0;
    case (opc)
      OPC_PG_RD:   begin kind = K_PGRD;   dummies = DCNT_W'(PG_DUMMY); end
      OPC_B0_RD:   begin kind = K_BUFRD;  dummies = DCNT_W'(BUF_DUMMY); end
      OPC_B1_RD:   begin kind = K_BUFRD;  dummies = DCNT_W'(BUF_DUMMY); bsel = 1'b1; end
      OPC_B0_WR:   kind = K_BUFWR;
      OPC_B1_WR:   begin kind = K_BUFWR;  bsel = 1'b1; end
      OPC_B0_PROG: kind = K_PGPROG;
      OPC_B1_PROG: begin kind = K_PGPROG; bsel = 1'b1; end
      default:     kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/dbuf_sram.sv
module dbuf_sram #(
  parameter int DEPTH = 264,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dbuf_cmd_front.sv
module dbuf_cmd_front
  import dbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_AW    = 12,
  parameter int BYTE_AW    = 9,
  parameter int PG_DUMMY   = 60,
  parameter int BUF_DUMMY  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_en,
  output logic [PAGE_AW-1:0] page_addr,
  output logic [BYTE_AW-1:0] byte_addr,
  input  logic [7:0]         arr_rd_data,
  output logic               prog_start,
  output logic               prog_buf
);
  localparam int DCNT_W = $clog2(PG_DUMMY + 1) < 2 ? 2 : $clog2(PG_DUMMY + 1);
  localparam int FLD_W  = PAGE_AW + BYTE_AW;
  localparam int HI_W   = FLD_W - 8;
  localparam int NBUF   = 2;
  localparam logic [BYTE_AW-1:0] SPAN = BYTE_AW'(PAGE_BYTES);
  localparam logic [BYTE_AW-1:0] LAST = BYTE_AW'(PAGE_BYTES - 1);

  phase_t              phase;
  kind_t               kind, dk;
  logic                bsel, dbs;
  logic [DCNT_W-1:0]   cnt, dneed, dd;
  logic [HI_W-1:0]     asr;
  logic [FLD_W-1:0]    full_addr;
  logic [PAGE_AW-1:0]  page;
  logic [BYTE_AW-1:0]  ptr, ptr_nxt;
  logic                cs_prev, start_q;
  logic                is_rd, is_wr, acc, ofire;
  logic [7:0]          brd [NBUF];

  function automatic logic [BYTE_AW-1:0] fold(input logic [BYTE_AW-1:0] a);
    return (a >= SPAN) ? a - SPAN : a;
  endfunction

  dbuf_opdec #(
    .PG_DUMMY (PG_DUMMY),
    .BUF_DUMMY(BUF_DUMMY),
    .DCNT_W   (DCNT_W)
  ) u_dec (
    .opc    (in_data),
    .kind   (dk),
    .bsel   (dbs),
    .dummies(dd)
  );

  assign is_rd     = (kind == K_PGRD) || (kind == K_BUFRD);
  assign is_wr     = (kind == K_BUFWR) || (kind == K_PGPROG);
  assign in_ready  = !((phase == PH_DATA) && is_rd);
  assign acc       = !cs_n && in_valid && in_ready;
  assign out_valid = !cs_n && (phase == PH_DATA) && is_rd;
  assign out_en    = !cs_n && (phase == PH_DATA) && is_rd;
  assign ofire     = out_valid && out_ready;
  assign full_addr = {asr, in_data};
  assign ptr_nxt   = (ptr == LAST) ? '0 : ptr + 1'b1;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    dbuf_sram #(.DEPTH(PAGE_BYTES), .AW(BYTE_AW)) u_ram (
      .clk  (clk),
      .we   (acc && (phase == PH_DATA) && is_wr && (bsel == 1'(g))),
      .waddr(ptr),
      .wdata(in_data),
      .raddr(ptr),
      .rdata(brd[g])
    );
  end

  assign out_data   = (kind == K_PGRD) ? arr_rd_data : brd[bsel];
  assign page_addr  = page;
  assign byte_addr  = ptr;
  assign prog_start = start_q;
  assign prog_buf   = bsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_OPC;
      kind    <= K_NONE;
      bsel    <= 1'b0;
      cnt     <= '0;
      dneed   <= '0;
      asr     <= '0;
      page    <= '0;
      ptr     <= '0;
      cs_prev <= 1'b1;
      start_q <= 1'b0;
    end else begin
      cs_prev <= cs_n;
      start_q <= cs_n && !cs_prev && (phase == PH_DATA) && (kind == K_PGPROG);
      if (cs_n) begin
        phase <= PH_OPC;
        cnt   <= '0;
      end else begin
        if (acc) begin
          case (phase)
            PH_OPC: begin
              cnt <= '0;
              if (dk != K_NONE) begin
                kind  <= dk;
                bsel  <= dbs;
                dneed <= dd;
                phase <= PH_ADDR;
              end else begin
                kind  <= K_NONE;
                phase <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              asr <= {asr[HI_W-9:0], in_data};
              if (cnt == DCNT_W'(2)) begin
                page  <= full_addr[BYTE_AW +: PAGE_AW];
                ptr   <= fold(full_addr[BYTE_AW-1:0]);
                cnt   <= '0;
                phase <= (dneed == '0) ? PH_DATA : PH_DUMMY;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DUMMY: begin
              if (cnt == DCNT_W'(dneed - 1'b1)) begin
                cnt   <= '0;
                phase <= PH_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_DATA: if (is_wr) ptr <= ptr_nxt;
            default: ;
          endcase
        end
        if (ofire) ptr <= ptr_nxt;
      end
    end
  end
endmodule

// File: rtl/dbuf_cmd_front_chk.sv
module dbuf_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_en,
  input logic       prog_start
);
  // R7
  cs_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!out_en && !out_valid));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (cs_n || $stable(out_data)));

  // R6
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R8
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind dbuf_cmd_front dbuf_cmd_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_en    (out_en),
  .prog_start(prog_start)
);

// File: tb/tb_dbuf_cmd_front.sv
`timescale 1ns/1ps
module tb_dbuf_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_en;
  logic [11:0] page_addr;
  logic [8:0]  byte_addr;
  logic [7:0]  arr_rd_data;
  logic        prog_start;
  logic        prog_buf;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  logic [11:0] lpage = '0;
  logic        lbuf = 1'b0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] amod(input logic [11:0] p, input logic [8:0] b);
    return p[7:0] * 8'd3 + b[7:0] + {b[8], 7'b0};
  endfunction

  assign arr_rd_data = amod(page_addr, byte_addr);

  dbuf_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_en(out_en), .page_addr(page_addr), .byte_addr(byte_addr),
    .arr_rd_data(arr_rd_data), .prog_start(prog_start), .prog_buf(prog_buf)
  );

  always @(negedge clk) begin
    if (prog_start) begin
      starts++;
      lpage = page_addr;
      lbuf  = prog_buf;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_tx();
    cs_n = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic end_tx();
    cs_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic hdr(input logic [7:0] op, input logic [23:0] a);
    push(op);
    push(a[23:16]);
    push(a[15:8]);
    push(a[7:0]);
  endtask

  task automatic pull(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, out_valid, 1'b1);
    chk(req, out_data, exp);
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_en", out_en, 1'b0);
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 prog_start", prog_start, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);
  endtask

  task automatic t_wrap();
    begin_tx(); hdr(8'h84, 24'd262); push(8'hAA); push(8'hBB); push(8'hCC); end_tx();
    begin_tx(); hdr(8'h54, 24'd262);
    @(negedge clk);
    chk("R3 no data before dummy", out_valid, 1'b0);
    @(posedge clk); #1;
    push(8'h00);
    pull("R2 R3 byte 262", 8'hAA);
    pull("R2 R3 byte 263", 8'hBB);
    pull("R2 R3 wrap to 0", 8'hCC);
    end_tx();
  endtask

  task automatic t_two_buf();
    begin_tx(); hdr(8'h84, 24'd36); push(8'h11); end_tx();
    begin_tx(); hdr(8'h87, 24'd300); push(8'h22); end_tx();
    begin_tx(); hdr(8'h56, 24'd36); push(8'h00); pull("R4 buf1 300 maps to 36", 8'h22); end_tx();
    begin_tx(); hdr(8'h54, 24'd300); push(8'h00); pull("R11 R4 buf0 untouched", 8'h11); end_tx();
  endtask

  task automatic t_backpressure();
    logic [7:0] first;
    begin_tx(); hdr(8'h54, 24'd262); push(8'h00);
    @(negedge clk);
    first = out_data;
    chk("R6 first byte", first, 8'hAA);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 valid held", out_valid, 1'b1);
      chk("R6 data stable", out_data, first);
      chk("R6 in_ready low", in_ready, 1'b0);
    end
    @(posedge clk); #1;
    pull("R6 take after stall", 8'hAA);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R7 out_en off", out_en, 1'b0);
    chk("R7 out_valid off", out_valid, 1'b0);
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic t_page_read();
    begin_tx(); hdr(8'h52, {3'b101, 12'h123, 9'd262});
    for (int i = 0; i < 59; i++) push(8'h00);
    @(negedge clk);
    chk("R5 silent after 59 dummies", out_valid, 1'b0);
    @(posedge clk); #1;
    push(8'h00);
    pull("R5 byte 262", amod(12'h123, 9'd262));
    pull("R5 byte 263", amod(12'h123, 9'd263));
    pull("R5 wrap same page", amod(12'h123, 9'd0));
    end_tx();
  endtask

  task automatic t_prog();
    int s0;
    s0 = starts;
    begin_tx(); hdr(8'h82, {3'b000, 12'h5A3, 9'd5}); push(8'hD0); push(8'hD1); end_tx();
    chk("R8 one pulse", starts, s0 + 1);
    chk("R8 page", lpage, 12'h5A3);
    chk("R8 buf0", lbuf, 1'b0);
    begin_tx(); hdr(8'h85, {3'b111, 12'h0FF, 9'd0}); end_tx();
    chk("R8 second pulse", starts, s0 + 2);
    chk("R8 page2", lpage, 12'h0FF);
    chk("R8 buf1", lbuf, 1'b1);
    begin_tx(); hdr(8'h54, 24'd5); push(8'h00);
    pull("R8 loaded byte 5", 8'hD0);
    pull("R8 loaded byte 6", 8'hD1);
    end_tx();
  endtask

  task automatic t_trunc();
    int s0;
    s0 = starts;
    begin_tx(); push(8'h82); push(8'h00); push(8'h01); end_tx();
    chk("R10 truncated no start", starts, s0);
    begin_tx(); hdr(8'h84, 24'd100); push(8'h5C); end_tx();
    chk("R10 write no start", starts, s0);
  endtask

  task automatic t_unknown();
    int s0;
    s0 = starts;
    begin_tx();
    push(8'h11); push(8'h00); push(8'h00); push(8'd36); push(8'h77); push(8'h00);
    @(negedge clk);
    chk("R9 no drive", out_en, 1'b0);
    chk("R9 still accepting", in_ready, 1'b1);
    @(posedge clk); #1;
    end_tx();
    chk("R9 no start", starts, s0);
    begin_tx(); hdr(8'h54, 24'd36); push(8'h00); pull("R9 buffer unchanged", 8'h11); end_tx();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_wrap();
    t_two_buf();
    t_backpressure();
    t_page_read();
    t_prog();
    t_trunc();
    t_unknown();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
  end
endmodule